// File: doc/BRIEF.md
# Composite Step Attenuator Controller

This block sets the output level of two signal channels from one attenuation request each. A request is given in tenths of a dB from 0 to 639. The block splits it into three hardware controls. The first is a 5-bit code for a 1 dB step attenuator. The second is a select for a fixed 32 dB pad, switched by a complementary relay pair. The third is an 8-bit fine-trim code that covers the tenths digit. The trim goes to two digital potentiometers per channel: one trims the gain and its partner cancels the DC offset that the gain change would cause.

The step and relay lines of both channels form one 24-bit image. The block shifts this image into three daisy-chained 8-bit external latches and then pulses a load strobe. Every step bit is driven as a true line and a complement line. The potentiometers are loaded over a 3-wire serial link. The gain and offset trim codes come from two 10-entry tables, indexed by the tenths digit and writable at run time.

When a request changes the state of the pad, the block first loads an image with both relays of that channel open. It then waits a programmable dead time before it closes the other relay. A busy flag stays high until all latch and potentiometer writes for the request are done. Requests that arrive while busy is high are dropped.

Top module: `atten_split_ctrl`

## Requirements
- R1: For a request A, the step code is floor(A/10) mod 32. The pad is switched in exactly when floor(A/10) >= 32.
- R2: A request above 639 is handled exactly as a request of 639.
- R3: A latch image is 24 bits, sent MSB first on lat_sdo and sampled on the rising edge of lat_sclk, followed by one lat_strobe pulse with lat_sclk low. Channel c occupies bits [12c+11:12c]. Within that group, bit 11 closes the pad relay, bit 10 closes the bypass relay, bits 9:5 hold the true step code and bits 4:0 its complement.
- R4: In every image, the complement lines equal the inverse of the true lines. The pad and bypass relays of a channel are never both closed, and in a final image exactly one of them is closed.
- R5: When a request changes a channel's pad state, a break image is sent first. In it, both relays of that channel are open, the new step code is present, and the other channel is unchanged. The first lat_sclk rise of the following final image comes no sooner than dead_cfg cycles after the break strobe.
- R6: When the pad state does not change, exactly one latch image is sent per request.
- R7: After the final image, two 10-bit potentiometer frames follow, MSB first: a 2-bit address, then 8 data bits. The gain frame goes to address {ch,0} and then the offset frame goes to address {ch,1}. pot_cs_n is low for the whole frame and pot_sclk pulses only while it is low.
- R8: The trim codes are gain_table[A mod 10] and offset_table[A mod 10]. After reset, entry i holds 25*i in the gain table and 255-25*i in the offset table. A one-cycle write with tbl_we=1 stores tbl_data into entry tbl_idx, where tbl_sel=0 selects the gain table and tbl_sel=1 the offset table. Later requests use the new value.
- R9: busy rises in the cycle after a request is accepted. It stays high until the offset frame ends. A req_valid that arrives while busy is high produces no output.
- R10: During and right after reset, busy=0, pot_cs_n=1, lat_sclk=0, pot_sclk=0 and lat_strobe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Attenuation request strobe |
| req_chan | input | 1 | Target channel |
| req_atten | input | 10 | Requested attenuation in tenths of a dB |
| dead_cfg | input | 8 | Relay dead time in cycles |
| tbl_we | input | 1 | Trim table write enable |
| tbl_sel | input | 1 | 0 gain table, 1 offset table |
| tbl_idx | input | 4 | Table entry index |
| tbl_data | input | 8 | Table write data |
| lat_sclk | output | 1 | Latch chain shift clock |
| lat_sdo | output | 1 | Latch chain serial data |
| lat_strobe | output | 1 | Latch load pulse |
| pot_sclk | output | 1 | Potentiometer serial clock |
| pot_sdo | output | 1 | Potentiometer serial data |
| pot_cs_n | output | 1 | Potentiometer chip select, active low |
| busy | output | 1 | Update in progress |

## Verification
Each channel's stored step and pad state is only visible through the next latch image. A wrong state therefore shows up as a wrong or missing break image, or as a wrong bit in the shifted image, within about fifty cycles of the next request. A wrong table entry or a wrong fine index shows up in the data bits of the potentiometer frames that follow the same request. A sequencer that leaves its idle state by mistake is caught one cycle later by busy, or by a frame that arrives when none is expected. A relay overlap or a missing complement line is seen at the latch strobe where it happens.

// File: rtl/atten_pkg.sv
package atten_pkg;
   localparam int REQ_W      = 10;
   localparam int STEP_W     = 5;
   localparam int FINE_W     = 4;
   localparam int MAX_TENTHS = 639;
   localparam int FINE_DEPTH = 10;
   localparam int GROUP_W    = 2 + 2*STEP_W;

   typedef struct packed {
      logic              pad;
      logic [STEP_W-1:0] step;
      logic [FINE_W-1:0] fine;
   } split_t;

   function automatic split_t split_req(input logic [REQ_W-1:0] r);
      split_t           s;
      logic [REQ_W-1:0] c;
      logic [REQ_W-1:0] whole;
      c      = (r > REQ_W'(MAX_TENTHS)) ? REQ_W'(MAX_TENTHS) : r;
      whole  = c / REQ_W'(10);
      s.step = whole[STEP_W-1:0];
      s.pad  = whole[STEP_W];
      s.fine = FINE_W'(c - whole * REQ_W'(10));
      return s;
   endfunction
endpackage

// File: rtl/atten_trim_table.sv
module atten_trim_table #(
   parameter int TRIM_W    = 8,
   parameter int TRIM_STEP = 25,
   parameter int DEPTH     = 10,
   parameter int IDX_W     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              sel,
   input  logic [IDX_W-1:0]  widx,
   input  logic [TRIM_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [TRIM_W-1:0] gain_o,
   output logic [TRIM_W-1:0] offs_o
);
   localparam int TOP_CODE = (1 << TRIM_W) - 1;

   logic [TRIM_W-1:0] gain_q [DEPTH];
   logic [TRIM_W-1:0] offs_q [DEPTH];

   initial begin
      if ((DEPTH - 1) * TRIM_STEP > TOP_CODE)
         $fatal(1, "trim step too large for code width");
      if ((1 << IDX_W) < DEPTH)
         $fatal(1, "index width too small for table depth");
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            gain_q[i] <= TRIM_W'(i * TRIM_STEP);
            offs_q[i] <= TRIM_W'(TOP_CODE - i * TRIM_STEP);
         end else if (we && widx == IDX_W'(i)) begin
            if (sel) offs_q[i] <= wdata;
            else     gain_q[i] <= wdata;
         end
      end
   end

   always_comb begin
      gain_o = '0;
      offs_o = '0;
      for (int k = 0; k < DEPTH; k++) begin
         if (ridx == IDX_W'(k)) begin
            gain_o = gain_q[k];
            offs_o = offs_q[k];
         end
      end
   end
endmodule

// File: rtl/atten_ser_shift.sv
module atten_ser_shift #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] word,
   output logic         sclk,
   output logic         sdo,
   output logic         active,
   output logic         done
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh;
   logic [CW-1:0] cnt;
   logic          ph;

   initial begin
      if (W < 2) $fatal(1, "shift word too short");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh     <= '0;
         cnt    <= '0;
         ph     <= 1'b0;
         sclk   <= 1'b0;
         active <= 1'b0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               sh     <= word;
               cnt    <= CW'(W);
               active <= 1'b1;
               ph     <= 1'b0;
               sclk   <= 1'b0;
            end
         end else if (!ph) begin
            sclk <= 1'b1;
            ph   <= 1'b1;
         end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            sh   <= {sh[W-2:0], 1'b0};
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               active <= 1'b0;
               done   <= 1'b1;
            end
         end
      end
   end

   assign sdo = active & sh[W-1];
endmodule

// File: rtl/atten_seq.sv
module atten_seq
   import atten_pkg::*;
#(
   parameter int NCH    = 2,
   parameter int CH_W   = 1,
   parameter int DEAD_W = 8,
   parameter int TRIM_W = 8,
   parameter int LAT_W  = 24,
   parameter int POT_W  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [CH_W-1:0]   req_chan,
   input  logic [REQ_W-1:0]  req_atten,
   input  logic [DEAD_W-1:0] dead_cfg,
   output logic [FINE_W-1:0] fine_idx,
   input  logic [TRIM_W-1:0] gain_code,
   input  logic [TRIM_W-1:0] offs_code,
   output logic              lat_start,
   output logic [LAT_W-1:0]  lat_word,
   input  logic              lat_done,
   output logic              pot_start,
   output logic [POT_W-1:0]  pot_word,
   input  logic              pot_done,
   output logic              busy
);
   localparam logic [GROUP_W-1:0] IDLE_GROUP = {1'b0, 1'b1, {STEP_W{1'b0}}, {STEP_W{1'b1}}};
   localparam logic [LAT_W-1:0]   RST_IMG    = {NCH{IDLE_GROUP}};

   typedef enum logic [2:0] {S_IDLE, S_BRK, S_DEAD, S_MAKE, S_POTG, S_POTO} st_t;

   st_t                          st;
   split_t                       sp;
   logic [NCH-1:0][STEP_W-1:0]   step_q;
   logic [NCH-1:0]               pad_q;
   logic [LAT_W-1:0]             img_fin, img_brk, fin_q;
   logic                         brk_need;
   logic [CH_W-1:0]              ch_q;
   logic [TRIM_W-1:0]            gain_q, offs_q;
   logic [DEAD_W-1:0]            dcnt;

   assign sp       = split_req(req_atten);
   assign fine_idx = sp.fine;
   assign brk_need = (sp.pad != pad_q[req_chan]);

   always_comb begin
      img_fin = '0;
      img_brk = '0;
      for (int c = 0; c < NCH; c++) begin
         logic              cur, p, off;
         logic [STEP_W-1:0] s;
         cur = (CH_W'(c) == req_chan);
         s   = cur ? sp.step : step_q[c];
         p   = cur ? sp.pad  : pad_q[c];
         off = cur & brk_need;
         img_fin[c*GROUP_W +: GROUP_W] = {p, ~p, s, ~s};
         img_brk[c*GROUP_W +: GROUP_W] = {p & ~off, ~p & ~off, s, ~s};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         step_q    <= '0;
         pad_q     <= '0;
         fin_q     <= RST_IMG;
         lat_word  <= RST_IMG;
         lat_start <= 1'b0;
         pot_start <= 1'b0;
         pot_word  <= '0;
         ch_q      <= '0;
         gain_q    <= '0;
         offs_q    <= '0;
         dcnt      <= '0;
      end else begin
         lat_start <= 1'b0;
         pot_start <= 1'b0;
         case (st)
            S_IDLE: if (req_valid) begin
               step_q[req_chan] <= sp.step;
               pad_q[req_chan]  <= sp.pad;
               fin_q            <= img_fin;
               ch_q             <= req_chan;
               gain_q           <= gain_code;
               offs_q           <= offs_code;
               lat_start        <= 1'b1;
               lat_word         <= brk_need ? img_brk : img_fin;
               st               <= brk_need ? S_BRK : S_MAKE;
            end
            S_BRK: if (lat_done) begin
               dcnt <= dead_cfg;
               st   <= S_DEAD;
            end
            S_DEAD: if (dcnt == '0) begin
               lat_start <= 1'b1;
               lat_word  <= fin_q;
               st        <= S_MAKE;
            end else begin
               dcnt <= dcnt - 1'b1;
            end
            S_MAKE: if (lat_done) begin
               pot_start <= 1'b1;
               pot_word  <= {ch_q, 1'b0, gain_q};
               st        <= S_POTG;
            end
            S_POTG: if (pot_done) begin
               pot_start <= 1'b1;
               pot_word  <= {ch_q, 1'b1, offs_q};
               st        <= S_POTO;
            end
            S_POTO: if (pot_done) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign busy = (st != S_IDLE);
endmodule

// File: rtl/atten_split_ctrl.sv
module atten_split_ctrl
   import atten_pkg::*;
#(
   parameter int NCH       = 2,
   parameter int DEAD_W    = 8,
   parameter int TRIM_W    = 8,
   parameter int TRIM_STEP = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_chan,
   input  logic [REQ_W-1:0]  req_atten,
   input  logic [DEAD_W-1:0] dead_cfg,
   input  logic              tbl_we,
   input  logic              tbl_sel,
   input  logic [3:0]        tbl_idx,
   input  logic [TRIM_W-1:0] tbl_data,
   output logic              lat_sclk,
   output logic              lat_sdo,
   output logic              lat_strobe,
   output logic              pot_sclk,
   output logic              pot_sdo,
   output logic              pot_cs_n,
   output logic              busy
);
   localparam int CH_W  = 1;
   localparam int PA_W  = CH_W + 1;
   localparam int LAT_W = NCH * GROUP_W;
   localparam int POT_W = PA_W + TRIM_W;

   initial begin
      if (NCH != 2) $fatal(1, "channel count must match the 1-bit channel select");
      if (TRIM_W < 1 || DEAD_W < 1) $fatal(1, "bad width");
   end

   logic [FINE_W-1:0] fine_idx;
   logic [TRIM_W-1:0] gain_code, offs_code;
   logic              lat_start, lat_done, lat_active;
   logic [LAT_W-1:0]  lat_word;
   logic              pot_start, pot_done, pot_active;
   logic [POT_W-1:0]  pot_word;

   atten_trim_table #(
      .TRIM_W(TRIM_W), .TRIM_STEP(TRIM_STEP), .DEPTH(FINE_DEPTH), .IDX_W(FINE_W)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n), .we(tbl_we), .sel(tbl_sel), .widx(tbl_idx),
      .wdata(tbl_data), .ridx(fine_idx), .gain_o(gain_code), .offs_o(offs_code)
   );

   atten_seq #(
      .NCH(NCH), .CH_W(CH_W), .DEAD_W(DEAD_W), .TRIM_W(TRIM_W),
      .LAT_W(LAT_W), .POT_W(POT_W)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_atten(req_atten), .dead_cfg(dead_cfg), .fine_idx(fine_idx),
      .gain_code(gain_code), .offs_code(offs_code),
      .lat_start(lat_start), .lat_word(lat_word), .lat_done(lat_done),
      .pot_start(pot_start), .pot_word(pot_word), .pot_done(pot_done),
      .busy(busy)
   );

   atten_ser_shift #(.W(LAT_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .start(lat_start), .word(lat_word),
      .sclk(lat_sclk), .sdo(lat_sdo), .active(lat_active), .done(lat_done)
   );

   atten_ser_shift #(.W(POT_W)) u_pot (
      .clk(clk), .rst_n(rst_n), .start(pot_start), .word(pot_word),
      .sclk(pot_sclk), .sdo(pot_sdo), .active(pot_active), .done(pot_done)
   );

   assign lat_strobe = lat_done;
   assign pot_cs_n   = ~pot_active;
endmodule

// File: rtl/atten_split_chk.sv
module atten_split_chk #(
   parameter int NCH = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                busy,
   input logic                lat_sclk,
   input logic                lat_strobe,
   input logic                lat_active,
   input logic                pot_sclk,
   input logic                pot_cs_n,
   input logic [NCH*12-1:0]   img
);
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_valid) |=> busy);

   a_r7_cs_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> pot_cs_n);

   a_r7_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      pot_sclk |-> !pot_cs_n);

   a_r3_strobe_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
      lat_strobe |-> (!lat_sclk && !lat_active));

   a_r3_sclk_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
      lat_sclk |-> lat_active);

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      a_r4_relay_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
         !(img[12*c+11] && img[12*c+10]));
      a_r4_step_complement: assert property (@(posedge clk) disable iff (!rst_n)
         img[12*c+9 -: 5] == ~img[12*c+4 -: 5]);
   end
endmodule

bind atten_split_ctrl atten_split_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
   .lat_sclk(lat_sclk), .lat_strobe(lat_strobe), .lat_active(lat_active),
   .pot_sclk(pot_sclk), .pot_cs_n(pot_cs_n), .img(lat_word)
);

// File: tb/atten_split_ctrl_test.sv
module atten_split_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_chan = 1'b0;
   logic [9:0] req_atten = '0;
   logic [7:0] dead_cfg = 8'd5;
   logic       tbl_we = 1'b0;
   logic       tbl_sel = 1'b0;
   logic [3:0] tbl_idx = '0;
   logic [7:0] tbl_data = '0;
   logic       lat_sclk, lat_sdo, lat_strobe, pot_sclk, pot_sdo, pot_cs_n, busy;

   always #2 clk = ~clk;

   atten_split_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chan(req_chan),
      .req_atten(req_atten), .dead_cfg(dead_cfg), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
      .tbl_idx(tbl_idx), .tbl_data(tbl_data), .lat_sclk(lat_sclk), .lat_sdo(lat_sdo),
      .lat_strobe(lat_strobe), .pot_sclk(pot_sclk), .pot_sdo(pot_sdo),
      .pot_cs_n(pot_cs_n), .busy(busy)
   );

   int checks = 0, fails = 0;
   bit finished = 0;
   longint cyc = 0;

   int stp_m[2], pad_m[2], gtab[10], otab[10];
   logic [23:0] exp_lat[$];
   bit          exp_brk[$];
   string       exp_lat_tag[$];
   logic [9:0]  exp_pot[$];
   string       exp_pot_tag[$];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [11:0] grp(int s, int p, int off);
      logic [4:0] sv;
      sv = 5'(s);
      return {(p == 1 && off == 0), (p == 0 && off == 0), sv, ~sv};
   endfunction

   always @(posedge clk) cyc++;

   // latch chain monitor
   logic [23:0] lsh = '0;
   int  lbits = 0;
   bit  lprev = 0, dwatch = 0;
   longint dt = 0;
   int  dead_seen = 0;
   always @(negedge clk) begin
      if (rst_n && lat_sclk && !lprev) begin
         lsh = {lsh[22:0], lat_sdo};
         lbits++;
         if (dwatch) begin
            chk((cyc - dt) >= dead_seen, "R5", "dead time gap", cyc - dt, dead_seen);
            dwatch = 0;
         end
      end
      lprev = lat_sclk;
      if (rst_n && lat_strobe) begin
         chk(lbits == 24, "R3", "latch bit count", lbits, 24);
         for (int c = 0; c < 2; c++) begin
            chk(!(lsh[12*c+11] && lsh[12*c+10]), "R4", "relay overlap", lsh, 0);
            chk(lsh[12*c+9 -: 5] == ~lsh[12*c+4 -: 5], "R4", "complement lines", lsh, 0);
         end
         if (exp_lat.size() == 0) chk(0, "R9", "unexpected latch image", lsh, 0);
         else begin
            logic [23:0] e;
            bit b;
            string t;
            e = exp_lat.pop_front(); b = exp_brk.pop_front(); t = exp_lat_tag.pop_front();
            chk(lsh == e, t, "latch image", lsh, e);
            if (b) begin dwatch = 1; dt = cyc; dead_seen = int'(dead_cfg); end
         end
         lbits = 0;
      end
   end

   // potentiometer link monitor
   logic [9:0] psh = '0;
   int  pbits = 0;
   bit  pprev = 0, csprev = 1;
   always @(negedge clk) begin
      if (rst_n && !pot_cs_n && pot_sclk && !pprev) begin
         psh = {psh[8:0], pot_sdo};
         pbits++;
      end
      pprev = pot_sclk;
      if (rst_n && pot_cs_n && !csprev) begin
         chk(pbits == 10, "R7", "pot bit count", pbits, 10);
         if (exp_pot.size() == 0) chk(0, "R9", "unexpected pot frame", psh, 0);
         else begin
            logic [9:0] e;
            string t;
            e = exp_pot.pop_front(); t = exp_pot_tag.pop_front();
            chk(psh == e, t, "pot frame", psh, e);
         end
         pbits = 0;
      end
      csprev = pot_cs_n;
   end

   task automatic do_req(int ch, int a, string tag);
      int c, w, s, p, f, brk, o;
      logic [23:0] img;
      c = (a > 639) ? 639 : a;
      w = c / 10; s = w % 32; p = (w >= 32) ? 1 : 0; f = c % 10;
      brk = (p != pad_m[ch]) ? 1 : 0;
      o = 1 - ch;
      if (brk != 0) begin
         img = '0;
         img[12*ch +: 12] = grp(s, p, 1);
         img[12*o +: 12]  = grp(stp_m[o], pad_m[o], 0);
         exp_lat.push_back(img); exp_brk.push_back(1); exp_lat_tag.push_back({tag, "/R5"});
      end
      img = '0;
      img[12*ch +: 12] = grp(s, p, 0);
      img[12*o +: 12]  = grp(stp_m[o], pad_m[o], 0);
      exp_lat.push_back(img); exp_brk.push_back(0); exp_lat_tag.push_back({tag, "/R1"});
      exp_pot.push_back({1'(ch), 1'b0, 8'(gtab[f])}); exp_pot_tag.push_back({tag, "/R8"});
      exp_pot.push_back({1'(ch), 1'b1, 8'(otab[f])}); exp_pot_tag.push_back({tag, "/R7"});
      stp_m[ch] = s; pad_m[ch] = p;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_chan = 1'(ch); req_atten = 10'(a); req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
      while (busy) @(negedge clk);
      chk(exp_lat.size() == 0 && exp_pot.size() == 0, brk ? "R5" : "R6",
          "frames outstanding", exp_lat.size() + exp_pot.size(), 0);
   endtask

   task automatic tbl_write(int sel, int idx, int val);
      @(negedge clk);
      tbl_we = 1'b1; tbl_sel = 1'(sel); tbl_idx = 4'(idx); tbl_data = 8'(val);
      @(negedge clk);
      tbl_we = 1'b0;
      if (sel == 0) gtab[idx] = val; else otab[idx] = val;
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      for (int i = 0; i < 10; i++) begin gtab[i] = 25 * i; otab[i] = 255 - 25 * i; end
      stp_m[0] = 0; stp_m[1] = 0; pad_m[0] = 0; pad_m[1] = 0;
      repeat (4) @(negedge clk);
      chk(busy == 0 && pot_cs_n == 1 && lat_sclk == 0 && pot_sclk == 0 && lat_strobe == 0,
          "R10", "outputs in reset", {busy, pot_cs_n, lat_sclk, pot_sclk, lat_strobe}, 5'b01000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy == 0 && pot_cs_n == 1 && lat_sclk == 0 && lat_strobe == 0,
          "R10", "outputs after reset", {busy, pot_cs_n, lat_sclk, lat_strobe}, 4'b0100);

      do_req(0, 0, "R1 zero");
      do_req(1, 157, "R1 mid");
      do_req(0, 325, "R5 pad in");
      do_req(0, 639, "R6 top");
      do_req(0, 1000, "R2 clamp");
      tbl_write(0, 3, 8'hA5);
      tbl_write(1, 3, 8'h5A);
      do_req(1, 3, "R8 table");
      do_req(0, 319, "R5 pad out");
      dead_cfg = 8'd20;
      do_req(1, 400, "R5 long dead");

      // R9: requests while busy are dropped
      fork
         do_req(1, 88, "R9 first");
         begin
            repeat (6) @(negedge clk);
            req_chan = 1'b0; req_atten = 10'd500; req_valid = 1'b1;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
         end
      join
      repeat (120) @(negedge clk);
      chk(exp_lat.size() == 0 && exp_pot.size() == 0 && busy == 0, "R9",
          "ignored request left no work", exp_lat.size() + exp_pot.size(), 0);
      do_req(0, 319, "R6 same pad");

      finished = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL R9 watchdog actual=hung expected=idle");
         summary();
         $finish;
      end
   end
endmodule